// File: doc/BRIEF.md
# Front Panel Indicator Stretch Controller

This block lights nine front panel indicator positions from thirteen event lines. Ten of the lines are request lines from two neighbouring logic devices, five from each. The other three are local status events: configuration done, bus access and trigger accept. Every line is resynchronised to the block clock. A mapping parameter then routes the line to one LED element, meaning one colour at one position. Each element has its own retriggerable hold counter, so an event that lasts one clock still lights its element long enough for the eye to catch it.

The positions are 1R, 2L, 2R, 3L, 3R, 4L, 4R, 5L and 5R. The first three have a green element only. The remaining six are bi-colour. Position 1L is not handled here. Each element's cathode goes to a pad that can only pull low. For each element the block gives a registered output enable and an active-low level. A pad wrapper combines the two into an open-drain driver.

The hold time is `HOLD_MS` milliseconds, and the hold count is derived from `CLK_HZ`. With the defaults of 40 MHz and 100 ms the count is 4,000,000 cycles.

Top module: `panel_lamp_ctrl`

## Requirements
- R1: During and right after reset, every `*_oe` bit is 0 and every `*_drv_n` bit is 1. A reset while an element is lit turns it off at the next edge, and the element stays off once reset ends.
- R2: For every element, `*_drv_n` is 0 exactly when its `*_oe` is 1. An element that is off is released and never driven high. Bit p of `grn_oe`/`grn_drv_n` is the green element of position p, with positions in the order 1R,2L,2R,3L,3R,4L,4R,5L,5R (bits 0..8). Bit k of `red_oe`/`red_drv_n` is the red element of 3L,3R,4L,4R,5L,5R (bits 0..5).
- R3: An input level sampled at a rising edge reaches the element enable at the fourth rising edge after it. This path covers two synchroniser flops, the hold counter and the output register.
- R4: An input that is high for one clock lights its element for exactly HOLD_CYCLES = CLK_HZ/1000*HOLD_MS cycles. An input that is high for L clocks lights it for L+HOLD_CYCLES-1 cycles.
- R5: A new request while the hold is running reloads the hold. The element goes off only HOLD_CYCLES cycles after the input was last seen high.
- R6: The red and green elements of one bi-colour position are never enabled together, and red wins. If green's own hold is still running when red's hold ends, green lights.
- R7: The default mapping sends `req_a[i]` to the red element of bi-colour position i (3L..5L) and `req_b[i]` to the green element of that same position. `evt[j]` goes to the green element of position j (1R, 2L, 2R).
- R8: The local status events pass through the same synchroniser and hold path as the external requests, with the same latency and hold.
- R9: Elements that no input maps to never light. With the default mapping these are green 5R and red 5R.
- R10: Any red element, and any green element of a green-only position, stays lit for at least HOLD_CYCLES consecutive cycles once it turns on, unless reset intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_a | input | 5 | Asynchronous request lines from the first source device |
| req_b | input | 5 | Asynchronous request lines from the second source device |
| evt | input | 3 | Local status events: configuration done, bus access, trigger accept |
| grn_oe | output | 9 | Pull-down enable per green element |
| grn_drv_n | output | 9 | Active-low level per green element |
| red_oe | output | 6 | Pull-down enable per red element |
| red_drv_n | output | 6 | Active-low level per red element |

## Verification
A single-cycle request and a ten-cycle request confirm the exact hold length and the four-edge latency. Two requests placed inside one hold window show that the hold reloads rather than expiring early. Simultaneous red and green requests on one position, followed by a green request that arrives after a red one and outlives it, separate plain suppression from the green hand-over when red expires. Firing every line at once shows that unmapped elements stay dark and that local events light their own positions. A reset during a lit hold confirms that the counters clear.

// File: rtl/lamp_pkg.sv
package lamp_pkg;
  localparam int N_REQ    = 5;              // request lines per source device
  localparam int N_EVT    = 3;              // local status events
  localparam int N_SRC    = 2 * N_REQ + N_EVT;
  localparam int N_GRN    = 9;              // positions with a green element
  localparam int N_RED    = 6;              // positions with a red element
  localparam int N_CH     = N_GRN + N_RED;  // element channels
  localparam int CH_W     = $clog2(N_CH + 1);
  localparam int RED_BASE = N_GRN - N_RED;  // first bi-colour position

  // Channel c < N_GRN: green of position c; c >= N_GRN: red of position RED_BASE+(c-N_GRN).
  // Any code >= N_CH leaves a source unrouted.
  function automatic logic [N_SRC*CH_W-1:0] default_map();
    logic [N_SRC*CH_W-1:0] m;
    m = '1;
    for (int i = 0; i < N_REQ; i++) begin
      m[i*CH_W +: CH_W]           = CH_W'(N_GRN + i);
      m[(N_REQ+i)*CH_W +: CH_W]   = CH_W'(RED_BASE + i);
    end
    for (int j = 0; j < N_EVT; j++)
      m[(2*N_REQ+j)*CH_W +: CH_W] = CH_W'(j);
    return m;
  endfunction
endpackage

// File: rtl/lamp_sync.sv
module lamp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d_async;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lamp_route.sv
module lamp_route #(
  parameter int                        N_SRC = 13,
  parameter int                        N_CH  = 15,
  parameter int                        CH_W  = 4,
  parameter logic [N_SRC*CH_W-1:0]     MAP   = '1
) (
  input  logic [N_SRC-1:0] src,
  output logic [N_CH-1:0]  trig
);
  always_comb begin
    trig = '0;
    for (int s = 0; s < N_SRC; s++) begin
      for (int c = 0; c < N_CH; c++) begin
        if (MAP[s*CH_W +: CH_W] == CH_W'(c))
          trig[c] = trig[c] | src[s];
      end
    end
  end
endmodule

// File: rtl/lamp_stretch.sv
module lamp_stretch #(
  parameter int N_CH = 15,
  parameter int HOLD = 4_000_000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] trig,
  output logic [N_CH-1:0] on
);
  localparam int CW = $clog2(HOLD + 1);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst)
        cnt <= '0;
      else if (trig[c])
        cnt <= CW'(HOLD);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end

    assign on[c] = (cnt != '0);
  end
endmodule

// File: rtl/lamp_encode.sv
module lamp_encode #(
  parameter int N_GRN    = 9,
  parameter int N_RED    = 6,
  parameter int RED_BASE = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_GRN+N_RED-1:0] on,
  output logic [N_GRN-1:0]       grn_oe,
  output logic [N_GRN-1:0]       grn_drv_n,
  output logic [N_RED-1:0]       red_oe,
  output logic [N_RED-1:0]       red_drv_n
);
  logic [N_GRN-1:0] g_show;
  logic [N_RED-1:0] r_show;

  for (genvar p = 0; p < N_GRN; p++) begin : g_pos
    if (p < RED_BASE) begin : g_mono
      assign g_show[p] = on[p];
    end else begin : g_bi
      assign g_show[p] = on[p] & ~on[N_GRN + p - RED_BASE];
    end
  end

  assign r_show = on[N_GRN +: N_RED];

  always_ff @(posedge clk) begin
    if (rst) begin
      grn_oe    <= '0;
      grn_drv_n <= '1;
      red_oe    <= '0;
      red_drv_n <= '1;
    end else begin
      grn_oe    <= g_show;
      grn_drv_n <= ~g_show;
      red_oe    <= r_show;
      red_drv_n <= ~r_show;
    end
  end
endmodule

// File: rtl/panel_lamp_ctrl.sv
module panel_lamp_ctrl
  import lamp_pkg::*;
#(
  parameter int                    CLK_HZ  = 40_000_000,
  parameter int                    HOLD_MS = 100,
  parameter logic [N_SRC*CH_W-1:0] SRC_MAP = default_map()
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req_a,
  input  logic [N_REQ-1:0] req_b,
  input  logic [N_EVT-1:0] evt,
  output logic [N_GRN-1:0] grn_oe,
  output logic [N_GRN-1:0] grn_drv_n,
  output logic [N_RED-1:0] red_oe,
  output logic [N_RED-1:0] red_drv_n
);
  localparam int HOLD_CYCLES = CLK_HZ / 1000 * HOLD_MS;

  logic [N_SRC-1:0] src_sync;
  logic [N_CH-1:0]  trig;
  logic [N_CH-1:0]  on;

  lamp_sync #(.W(N_SRC)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({evt, req_b, req_a}),
    .q       (src_sync)
  );

  lamp_route #(.N_SRC(N_SRC), .N_CH(N_CH), .CH_W(CH_W), .MAP(SRC_MAP)) u_route (
    .src  (src_sync),
    .trig (trig)
  );

  lamp_stretch #(.N_CH(N_CH), .HOLD(HOLD_CYCLES)) u_stretch (
    .clk  (clk),
    .rst  (rst),
    .trig (trig),
    .on   (on)
  );

  lamp_encode #(.N_GRN(N_GRN), .N_RED(N_RED), .RED_BASE(RED_BASE)) u_encode (
    .clk       (clk),
    .rst       (rst),
    .on        (on),
    .grn_oe    (grn_oe),
    .grn_drv_n (grn_drv_n),
    .red_oe    (red_oe),
    .red_drv_n (red_drv_n)
  );
endmodule

// File: rtl/lamp_chk.sv
module lamp_chk
  import lamp_pkg::*;
#(
  parameter int HOLD = 4_000_000
) (
  input logic             clk,
  input logic             rst,
  input logic [N_GRN-1:0] grn_oe,
  input logic [N_GRN-1:0] grn_drv_n,
  input logic [N_RED-1:0] red_oe,
  input logic [N_RED-1:0] red_drv_n
);
  localparam int N_W = N_RED + RED_BASE;

  // R1: outputs come out of reset dark and released
  a_r1_reset_off: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (grn_oe == '0 && red_oe == '0 && grn_drv_n == '1 && red_drv_n == '1));

  // R2: the low level is presented only while the pull-down is enabled
  a_r2_level: assert property (@(posedge clk) disable iff (rst)
    (grn_drv_n == ~grn_oe) && (red_drv_n == ~red_oe));

  // R6: one colour per bi-colour position
  for (genvar k = 0; k < N_RED; k++) begin : g_excl
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(red_oe[k] && grn_oe[RED_BASE + k]));
  end

  // R10: minimum lit run, measured with a counter per watched element
  logic [N_W-1:0] watched;
  assign watched = {red_oe, grn_oe[RED_BASE-1:0]};

  for (genvar e = 0; e < N_W; e++) begin : g_run
    logic [31:0] run;
    always_ff @(posedge clk) begin
      if (rst)
        run <= '0;
      else if (watched[e])
        run <= (run == 32'hFFFF_FFFF) ? run : run + 1;
      else
        run <= '0;
    end

    a_r10_min_on: assert property (@(posedge clk) disable iff (rst)
      (!watched[e] && run != 0) |-> (run >= 32'(HOLD)));
  end
endmodule

bind panel_lamp_ctrl lamp_chk #(.HOLD(HOLD_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .grn_oe    (grn_oe),
  .grn_drv_n (grn_drv_n),
  .red_oe    (red_oe),
  .red_drv_n (red_drv_n)
);

// File: tb/sim_panel_lamp_ctrl.sv
module sim_panel_lamp_ctrl;
  localparam int CLK_HZ  = 20_000;
  localparam int HOLD_MS = 1;
  localparam int HOLD    = CLK_HZ / 1000 * HOLD_MS;  // 20 cycles

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] req_a = '0;
  logic [4:0] req_b = '0;
  logic [2:0] evt = '0;
  logic [8:0] grn_oe, grn_drv_n;
  logic [5:0] red_oe, red_drv_n;

  panel_lamp_ctrl #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) u0 (
    .clk(clk), .rst(rst), .req_a(req_a), .req_b(req_b), .evt(evt),
    .grn_oe(grn_oe), .grn_drv_n(grn_drv_n), .red_oe(red_oe), .red_drv_n(red_drv_n)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; int elem; bit lit; string tag; } item_t;
  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // element e: 0..8 green of 1R..5R, 9..14 red of 3L..5R
  task automatic push(input int at, input int elem, input bit lit, input string tag);
    item_t it;
    it.at = at; it.elem = elem; it.lit = lit; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expect_pulse(input int elem, input int k, input int len, input string tag);
    push(k + 3, elem, 1'b0, tag);
    push(k + 4, elem, 1'b1, tag);
    push(k + len + 2 + HOLD, elem, 1'b1, tag);
    push(k + len + 3 + HOLD, elem, 1'b0, tag);
  endtask

  task automatic set_src(input int s, input logic v);
    if (s < 5)       req_a[s] = v;
    else if (s < 10) req_b[s-5] = v;
    else             evt[s-10] = v;
  endtask

  task automatic drive(input int s, input int len);
    set_src(s, 1'b1);
    repeat (len) @(negedge clk);
    set_src(s, 1'b0);
  endtask

  task automatic settle();
    repeat (HOLD + 15) @(negedge clk);
  endtask

  task automatic direct(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: compares scheduled expectations and the level pairing (R2)
  always @(negedge clk) begin
    logic [14:0] oe_v;
    oe_v = {red_oe, grn_oe};
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        direct(oe_v[sb[i].elem] == sb[i].lit,
               $sformatf("%s elem %0d cyc %0d", sb[i].tag, sb[i].elem, cyc),
               oe_v[sb[i].elem], sb[i].lit);
        sb.delete(i);
      end
    end
    if (!rst)
      direct({red_drv_n, grn_drv_n} == ~oe_v, "R2 level pairing",
             {red_drv_n, grn_drv_n}, ~oe_v);
  end

  initial begin
    repeat (200_000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1: reset state
    direct(grn_oe == '0 && red_oe == '0, "R1 oe in reset", {red_oe, grn_oe}, 0);
    direct(grn_drv_n == '1 && red_drv_n == '1, "R1 level in reset",
           {red_drv_n, grn_drv_n}, 15'h7FFF);
    rst = 1'b0;
    @(negedge clk);

    // R4/R3: one-cycle request, red 3L via req_a[0]
    k = cyc; expect_pulse(9, k, 1, "R4 single-cycle"); drive(0, 1); settle();

    // R7/R3: ten-cycle request on req_b[1] -> green 3R
    k = cyc; expect_pulse(4, k, 10, "R7 long request"); drive(6, 10); settle();

    // R5: retrigger req_a[2] (red 4L) inside the hold window
    k = cyc;
    push(k + 4, 11, 1'b1, "R5 retrigger");
    push(k + 4 + HOLD, 11, 1'b1, "R5 retrigger held");
    push(k + 13 + HOLD, 11, 1'b1, "R5 retrigger end");
    push(k + 14 + HOLD, 11, 1'b0, "R5 retrigger off");
    drive(2, 1); repeat (9) @(negedge clk); drive(2, 1); settle();

    // R6: red and green of 4R at once -> red only
    k = cyc;
    expect_pulse(12, k, 1, "R6 red wins");
    push(k + 4, 6, 1'b0, "R6 green held off");
    push(k + 3 + HOLD, 6, 1'b0, "R6 green held off");
    push(k + 4 + HOLD, 6, 1'b0, "R6 green after");
    set_src(3, 1'b1); set_src(8, 1'b1); @(negedge clk);
    set_src(3, 1'b0); set_src(8, 1'b0); settle();

    // R6: green of 5L outlives red of 5L and shows after it
    k = cyc;
    push(k + 4, 13, 1'b1, "R6 red first");
    push(k + 3 + HOLD, 13, 1'b1, "R6 red last");
    push(k + 4 + HOLD, 13, 1'b0, "R6 red off");
    push(k + 9, 7, 1'b0, "R6 green masked");
    push(k + 4 + HOLD, 7, 1'b1, "R6 green hand-over");
    push(k + 8 + HOLD, 7, 1'b1, "R6 green last");
    push(k + 9 + HOLD, 7, 1'b0, "R6 green off");
    drive(4, 1); repeat (4) @(negedge clk); drive(9, 1); settle();

    // R8: local event evt[1] -> green 2L
    k = cyc; expect_pulse(1, k, 3, "R8 local event"); drive(11, 3); settle();

    // R9: every line at once; unmapped 5R elements stay dark
    k = cyc;
    push(k + 4, 8, 1'b0, "R9 green 5R dark");
    push(k + 4, 14, 1'b0, "R9 red 5R dark");
    push(k + 10, 8, 1'b0, "R9 green 5R dark");
    push(k + 10, 14, 1'b0, "R9 red 5R dark");
    push(k + 4, 0, 1'b1, "R8 evt0 lights 1R");
    req_a = '1; req_b = '1; evt = '1; @(negedge clk);
    req_a = '0; req_b = '0; evt = '0; settle();

    // R1: reset while lit clears the hold
    k = cyc;
    push(k + 4, 9, 1'b1, "R1 lit before reset");
    push(k + 9, 9, 1'b0, "R1 cleared by reset");
    push(k + 15, 9, 1'b0, "R1 stays off");
    drive(0, 1); repeat (7) @(negedge clk);
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    settle();

    direct(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    finish_up();
  end
endmodule